// File: doc/BRIEF.md
# One-Time-Programmable Fuse Controller

This block is the register front end for a one-time-programmable fuse array. Software reaches it through a single-port word register bus and works with five registers: a status word, a fuse address, a data byte, a configuration word and an index/strap word. A sixth, write-only register takes commands. A read command copies one byte of the fuse array into the data register. A program command sets exactly one fuse bit. A program only starts after a two-write unlock sequence on the command register, and it can never clear a bit.

The fuse array is held inside the block as a byte memory of 2^ARRAY_AW entries, cleared by reset. The data register is BYTE_W = 2^BITPOS_W bits wide. Each command is captured on one clock edge and carried out on the following edge, using the address captured with the command. Read responses come back one cycle after the request. Any access to an offset the block does not decode raises a one-cycle error pulse.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, status (offset 0) reads 0x00000001, configuration (offset 3) reads 0x20000000, and address (1), data (2), index (4) and command (5) read 0.
- R2: The address register keeps only bits 12:0 of a write: the byte address in bits 9:0 and the bit position in bits 12:10. All other bits read back as 0.
- R3: Writing 0x00000002 to the command register loads the addressed array byte into the data register, zero-extended, and sets status bit 1 (done) and bit 0 (ready).
- R4: The program operation runs when 0xBF79E5D0 is written to the command register and the previous command-register write was 0x00000001. Accesses to other registers in between do not break the sequence. The program operation ORs a one into the addressed bit of the addressed byte and sets status bits 1 and 0.
- R5: Any command write other than 0x00000001 disarms the sequence. 0xBF79E5D0 without the arming write changes no fuse. The command register always reads back 0.
- R6: Writing a 1 to status bit 1 clears it. Software cannot set status bits 1 and 0. Status bit 2 (interrupt enable) is plain read/write. Status bits 31:3 read 0.
- R7: A data-register write of exactly 0x00000001 clears the data register. Any other written value leaves it unchanged.
- R8: A command captured on one edge is carried out on the next edge. It uses the address held when the command was written. A read issued in the cycle after the command still returns the old values.
- R9: When an operation completes in the same cycle as a status write, status bit 1 ends up set, while bit 2 still takes the written value. When a read completes in the same cycle as a data-clear write, the loaded byte wins.
- R10: An access to an offset from 6 upward changes no register. A read of such an offset returns 0. In both cases the error output is high for exactly the next cycle.
- R11: Configuration (offset 3) and index (offset 4) are plain 32-bit read/write registers.
- R12: A fuse bit that reads 1 never returns to 0. Programming a bit that is already set leaves the byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; also clears the fuse array |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ofs | input | OFS_W | Word offset of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| bus_err | output | 1 | One-cycle pulse after an access to an undecoded offset |

## Verification
Because each operation finishes one edge after its command, its completion can fall in the same cycle as a new bus write. The bench forces this on purpose. A status write that clears the done flag and sets interrupt enable is placed in the cycle right after a read command, and the status word must then read 0x7. It repeats this with a program command followed by a status write. In a separate case, a data-clear write follows a read command directly, and the data register must then hold the fuse byte rather than zero. The same spacing also shows that an address write in the completion cycle does not redirect the operation already in flight.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned NREG   = 6;

  // word offsets of the decoded registers
  localparam int unsigned OFS_STAT = 0;
  localparam int unsigned OFS_ADDR = 1;
  localparam int unsigned OFS_DATA = 2;
  localparam int unsigned OFS_CFG  = 3;
  localparam int unsigned OFS_IDX  = 4;
  localparam int unsigned OFS_CMD  = 5;

  localparam logic [WORD_W-1:0] CMD_READ  = 32'h0000_0002;
  localparam logic [WORD_W-1:0] CMD_ARM   = 32'h0000_0001;
  localparam logic [WORD_W-1:0] CMD_FIRE  = 32'hBF79_E5D0;
  localparam logic [WORD_W-1:0] DATA_WIPE = 32'h0000_0001;
  localparam logic [WORD_W-1:0] CFG_RST   = 32'h2000_0000;

  localparam int unsigned ST_READY = 0;
  localparam int unsigned ST_DONE  = 1;
  localparam int unsigned ST_IEN   = 2;

  typedef struct packed {
    logic ien;
    logic done;
    logic ready;
  } stat_t;

  localparam stat_t STAT_RST = '{ien: 1'b0, done: 1'b0, ready: 1'b1};

  // software write to status: done is write-1-to-clear, ready is read-only
  function automatic stat_t stat_on_write(stat_t cur, logic [WORD_W-1:0] wd);
    stat_t nx;
    nx     = cur;
    nx.ien = wd[ST_IEN];
    if (wd[ST_DONE]) nx.done = 1'b0;
    return nx;
  endfunction

  // operation completion: applied after the software write, so it wins
  function automatic stat_t stat_on_done(stat_t cur);
    stat_t nx;
    nx       = cur;
    nx.done  = 1'b1;
    nx.ready = 1'b1;
    return nx;
  endfunction

  // command register keeps only the arming value
  function automatic logic cmd_arms(logic [WORD_W-1:0] wd);
    return wd == CMD_ARM;
  endfunction

endpackage

// File: rtl/otp_reg_decode.sv
module otp_reg_decode
  import otp_fuse_pkg::*;
#(
  parameter int unsigned OFS_W = 4
) (
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_ofs,
  output logic [NREG-1:0]  wr_en,
  output logic [NREG-1:0]  rd_hit,
  output logic             bad_acc
);

  logic [NREG-1:0] ofs_hit;

  for (genvar g = 0; g < NREG; g++) begin : g_hit
    assign ofs_hit[g] = (req_ofs == OFS_W'(g));
    assign wr_en[g]   = req_valid && req_write && ofs_hit[g];
    assign rd_hit[g]  = req_valid && !req_write && ofs_hit[g];
  end

  assign bad_acc = req_valid && !(|ofs_hit);

  initial begin
    assert (NREG <= (1 << OFS_W)); // R10: every decoded offset must be reachable
  end

endmodule

// File: rtl/otp_cmd_seq.sv
module otp_cmd_seq
  import otp_fuse_pkg::*;
#(
  parameter int unsigned ARRAY_AW = 10,
  parameter int unsigned BITPOS_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [WORD_W-1:0]   cmd_wdata,
  input  logic [ARRAY_AW-1:0] cur_byte,
  input  logic [BITPOS_W-1:0] cur_bit,
  output logic                exec_rd,
  output logic                exec_pgm,
  output logic [ARRAY_AW-1:0] exec_byte,
  output logic [BITPOS_W-1:0] exec_bit
);

  logic armed_q;
  logic pend_rd_q, pend_pgm_q;
  logic [ARRAY_AW-1:0] byte_q;
  logic [BITPOS_W-1:0] bit_q;

  logic want_rd, want_pgm;
  assign want_rd  = cmd_wr && (cmd_wdata == CMD_READ);
  assign want_pgm = cmd_wr && (cmd_wdata == CMD_FIRE) && armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q    <= 1'b0;
      pend_rd_q  <= 1'b0;
      pend_pgm_q <= 1'b0;
      byte_q     <= '0;
      bit_q      <= '0;
    end else begin
      if (cmd_wr) armed_q <= cmd_arms(cmd_wdata);
      pend_rd_q  <= want_rd;
      pend_pgm_q <= want_pgm;
      if (want_rd || want_pgm) begin
        byte_q <= cur_byte;
        bit_q  <= cur_bit;
      end
    end
  end

  assign exec_rd   = pend_rd_q;
  assign exec_pgm  = pend_pgm_q;
  assign exec_byte = byte_q;
  assign exec_bit  = bit_q;

  a_r8_read_one_edge_late: assert property (@(posedge clk) disable iff (!rst_n)
    exec_rd |-> $past(cmd_wr && (cmd_wdata == CMD_READ)));

  a_r4_fire_after_fire_write: assert property (@(posedge clk) disable iff (!rst_n)
    exec_pgm |-> $past(cmd_wr && (cmd_wdata == CMD_FIRE)));

  a_r5_one_op_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_rd && exec_pgm));

endmodule

// File: rtl/otp_fuse_mem.sv
module otp_fuse_mem #(
  parameter int unsigned ARRAY_AW = 10,
  parameter int unsigned BITPOS_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pgm_en,
  input  logic [ARRAY_AW-1:0] sel_byte,
  input  logic [BITPOS_W-1:0] sel_bit,
  output logic [(1<<BITPOS_W)-1:0] rd_data
);

  localparam int unsigned BYTE_W = 1 << BITPOS_W;
  localparam int unsigned DEPTH  = 1 << ARRAY_AW;

  logic [BYTE_W-1:0] mem_q [DEPTH];

  function automatic logic [BYTE_W-1:0] bit_mask(logic [BITPOS_W-1:0] pos);
    return {{(BYTE_W-1){1'b0}}, 1'b1} << pos;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (pgm_en) begin
      mem_q[sel_byte] <= mem_q[sel_byte] | bit_mask(sel_bit);
    end
  end

  assign rd_data = mem_q[sel_byte];

  a_r12_no_lost_one: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |=> ((mem_q[$past(sel_byte)] & $past(rd_data)) == $past(rd_data)));

  a_r4_bit_lands: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_en |=> mem_q[$past(sel_byte)][$past(sel_bit)]);

endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int unsigned OFS_W    = 4,
  parameter int unsigned ARRAY_AW = 10,
  parameter int unsigned BITPOS_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFS_W-1:0] req_ofs,
  input  logic [31:0]      req_wdata,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             bus_err
);

  localparam int unsigned BYTE_W = 1 << BITPOS_W;
  localparam int unsigned ADDR_W = ARRAY_AW + BITPOS_W;
  localparam int unsigned STAT_W = $bits(stat_t);

  logic [NREG-1:0] wr_en, rd_hit;
  logic            bad_acc;

  stat_t             stat_q, stat_n;
  logic [ADDR_W-1:0] addr_q;
  logic [BYTE_W-1:0] data_q;
  logic [WORD_W-1:0] cfg_q, idx_q;
  logic [WORD_W-1:0] rd_word;

  logic                exec_rd, exec_pgm;
  logic [ARRAY_AW-1:0] exec_byte;
  logic [BITPOS_W-1:0] exec_bit;
  logic [BYTE_W-1:0]   mem_rdata;

  logic                rsp_valid_q, bus_err_q;
  logic [WORD_W-1:0]   rsp_rdata_q;

  otp_reg_decode #(.OFS_W(OFS_W)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ofs   (req_ofs),
    .wr_en     (wr_en),
    .rd_hit    (rd_hit),
    .bad_acc   (bad_acc)
  );

  otp_cmd_seq #(.ARRAY_AW(ARRAY_AW), .BITPOS_W(BITPOS_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (wr_en[OFS_CMD]),
    .cmd_wdata (req_wdata),
    .cur_byte  (addr_q[ARRAY_AW-1:0]),
    .cur_bit   (addr_q[ADDR_W-1:ARRAY_AW]),
    .exec_rd   (exec_rd),
    .exec_pgm  (exec_pgm),
    .exec_byte (exec_byte),
    .exec_bit  (exec_bit)
  );

  otp_fuse_mem #(.ARRAY_AW(ARRAY_AW), .BITPOS_W(BITPOS_W)) u_mem (
    .clk      (clk),
    .rst_n    (rst_n),
    .pgm_en   (exec_pgm),
    .sel_byte (exec_byte),
    .sel_bit  (exec_bit),
    .rd_data  (mem_rdata)
  );

  // status: software write first, completion last so that it wins
  always_comb begin
    stat_n = stat_q;
    if (wr_en[OFS_STAT]) stat_n = stat_on_write(stat_n, req_wdata);
    if (exec_rd || exec_pgm) stat_n = stat_on_done(stat_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      addr_q <= '0;
      data_q <= '0;
      cfg_q  <= CFG_RST;
      idx_q  <= '0;
    end else begin
      stat_q <= stat_n;
      if (wr_en[OFS_ADDR]) addr_q <= req_wdata[ADDR_W-1:0];
      if (exec_rd) data_q <= mem_rdata;
      else if (wr_en[OFS_DATA] && (req_wdata == DATA_WIPE)) data_q <= '0;
      if (wr_en[OFS_CFG]) cfg_q <= req_wdata;
      if (wr_en[OFS_IDX]) idx_q <= req_wdata;
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_hit[OFS_STAT]) rd_word = {{(WORD_W-STAT_W){1'b0}}, stat_q};
    if (rd_hit[OFS_ADDR]) rd_word = {{(WORD_W-ADDR_W){1'b0}}, addr_q};
    if (rd_hit[OFS_DATA]) rd_word = {{(WORD_W-BYTE_W){1'b0}}, data_q};
    if (rd_hit[OFS_CFG])  rd_word = cfg_q;
    if (rd_hit[OFS_IDX])  rd_word = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      bus_err_q   <= 1'b0;
    end else begin
      rsp_valid_q <= req_valid && !req_write;
      rsp_rdata_q <= rd_word;
      bus_err_q   <= bad_acc;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_rdata_q;
  assign bus_err   = bus_err_q;

  a_r6_ready_never_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(stat_q.ready));

  a_r9_done_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_rd || exec_pgm) |=> stat_q.done);

  a_r3_data_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    exec_rd |=> (data_q == $past(mem_rdata)));

  a_r7_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en[OFS_DATA] && (req_wdata != DATA_WIPE) && !exec_rd) |=> $stable(data_q));

  a_r10_err_from_bad_ofs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> ($past(req_valid) && ($past(req_ofs) >= OFS_W'(NREG))));

  a_r10_rsp_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));

endmodule

// File: tb/otp_fuse_ctrl_tb_top.sv
module otp_fuse_ctrl_tb_top;

  localparam int OFS_W = 4;
  localparam logic [31:0] FIRE = 32'hBF79_E5D0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_write = 1'b0;
  logic [OFS_W-1:0] req_ofs = '0;
  logic [31:0]      req_wdata = '0;
  logic             rsp_valid;
  logic [31:0]      rsp_rdata;
  logic             bus_err;

  always #10 clk = ~clk;

  otp_fuse_ctrl #(.OFS_W(OFS_W), .ARRAY_AW(10), .BITPOS_W(3)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ofs   (req_ofs),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .bus_err   (bus_err)
  );

  typedef struct {
    bit          is_rd;
    logic [31:0] exp;
    bit          exp_err;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  // driver: one bus cycle per call, expectation queued for the monitor
  task automatic cyc(bit v, bit w, int ofs, logic [31:0] d, logic [31:0] exp, string tag);
    item_t it;
    @(negedge clk);
    req_valid = v;
    req_write = w;
    req_ofs   = OFS_W'(ofs);
    req_wdata = d;
    it.is_rd   = v && !w;
    it.exp     = exp;
    it.exp_err = v && (ofs >= 6);
    it.tag     = tag;
    exp_q.push_back(it);
  endtask

  task automatic wr(int ofs, logic [31:0] d, string tag);
    cyc(1'b1, 1'b1, ofs, d, 32'h0, tag);
  endtask

  task automatic rd(int ofs, logic [31:0] exp, string tag);
    cyc(1'b1, 1'b0, ofs, 32'h0, exp, tag);
  endtask

  task automatic idle();
    cyc(1'b0, 1'b0, 0, 32'h0, 32'h0, "idle");
  endtask

  // monitor: compares each response after the edge that produced it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        if (it.is_rd) begin
          n_chk++;
          if (!rsp_valid || rsp_rdata !== it.exp) begin
            n_fail++;
            $display("FAIL %s: read got valid=%0b data=%h, expected valid=1 data=%h",
                     it.tag, rsp_valid, rsp_rdata, it.exp);
          end
        end else if (rsp_valid) begin
          n_chk++;
          n_fail++;
          $display("FAIL R10: unexpected rsp_valid got 1 expected 0 (%s)", it.tag);
        end
        if (it.exp_err || bus_err) begin
          n_chk++;
          if (bus_err !== it.exp_err) begin
            n_fail++;
            $display("FAIL R10: bus_err got %0b expected %0b (%s)", bus_err, it.exp_err, it.tag);
          end
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(200000 * 20);
    if (!done_flag) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run got stuck, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(0, 32'h1, "R1");
    rd(1, 32'h0, "R1");
    rd(2, 32'h0, "R1");
    rd(3, 32'h2000_0000, "R1");
    rd(4, 32'h0, "R1");
    rd(5, 32'h0, "R1");

    // R11 plain registers
    wr(3, 32'hA5A5_0F0F, "R11");
    rd(3, 32'hA5A5_0F0F, "R11");
    wr(4, 32'h1234_5678, "R11");
    rd(4, 32'h1234_5678, "R11");

    // R2 address field masking: byte 1023, bit 7
    wr(1, 32'hFFFF_FFFF, "R2");
    rd(1, 32'h0000_1FFF, "R2");

    // R4 program at the top byte, then R3 read it
    wr(5, 32'h1, "R4");
    wr(5, FIRE, "R4");
    idle();
    rd(0, 32'h3, "R4");
    wr(5, 32'h2, "R3");
    idle();
    rd(2, 32'h80, "R3");

    // R6 status behaviour
    wr(0, 32'h2, "R6");
    rd(0, 32'h1, "R6");
    wr(0, 32'h5, "R6");
    rd(0, 32'h5, "R6");
    wr(0, 32'hFFFF_FFF8, "R6");
    rd(0, 32'h1, "R6");
    wr(0, 32'h1, "R6");
    rd(0, 32'h1, "R6");

    // R7 data register write rules
    wr(2, 32'h80, "R7");
    rd(2, 32'h80, "R7");
    wr(2, 32'hFFFF_FFFF, "R7");
    rd(2, 32'h80, "R7");
    wr(2, 32'h1, "R7");
    rd(2, 32'h0, "R7");

    // R5 broken unlock: byte 5 bit 3
    wr(1, (32'd3 << 10) | 32'd5, "R5");
    wr(5, 32'h1, "R5");
    wr(5, 32'h7, "R5");
    wr(5, FIRE, "R5");
    idle();
    wr(5, 32'h2, "R5");
    idle();
    rd(2, 32'h0, "R5");

    // R4 arm, unrelated accesses, fire
    wr(5, 32'h1, "R4");
    rd(5, 32'h0, "R5");
    rd(0, 32'h3, "R4");
    wr(5, FIRE, "R4");
    idle();
    wr(5, 32'h2, "R4");
    idle();
    rd(2, 32'h08, "R4");

    // R5 fire without arming (command already back to 0)
    wr(1, (32'd6 << 10) | 32'd5, "R5");
    wr(5, FIRE, "R5");
    idle();
    wr(5, 32'h2, "R5");
    idle();
    rd(2, 32'h08, "R5");

    // R4 double arm still unlocks
    wr(5, 32'h1, "R4");
    wr(5, 32'h1, "R4");
    wr(5, FIRE, "R4");
    idle();
    wr(5, 32'h2, "R4");
    idle();
    rd(2, 32'h48, "R4");

    // R12 reprogramming a set bit changes nothing
    wr(5, 32'h1, "R12");
    wr(5, FIRE, "R12");
    idle();
    wr(5, 32'h2, "R12");
    idle();
    rd(2, 32'h48, "R12");

    // R4 lowest byte, lowest bit; R12 top byte kept
    wr(1, 32'h0, "R4");
    wr(5, 32'h1, "R4");
    wr(5, FIRE, "R4");
    idle();
    wr(5, 32'h2, "R4");
    idle();
    rd(2, 32'h01, "R4");
    wr(1, 32'h3FF, "R12");
    wr(5, 32'h2, "R12");
    idle();
    rd(2, 32'h80, "R12");

    // R8 read latency
    wr(2, 32'h1, "R8");
    wr(1, 32'd5, "R8");
    wr(5, 32'h2, "R8");
    rd(2, 32'h0, "R8");
    rd(2, 32'h48, "R8");

    // R8 address captured with a read command
    wr(2, 32'h1, "R8");
    wr(1, 32'd5, "R8");
    wr(5, 32'h2, "R8");
    wr(1, 32'h3FF, "R8");
    idle();
    rd(2, 32'h48, "R8");

    // R8 address captured with a program command: byte 7 bit 2
    wr(1, (32'd2 << 10) | 32'd7, "R8");
    wr(5, 32'h1, "R8");
    wr(5, FIRE, "R8");
    wr(1, (32'd4 << 10) | 32'd8, "R8");
    idle();
    wr(5, 32'h2, "R8");
    idle();
    rd(2, 32'h0, "R8");
    wr(1, 32'd7, "R8");
    wr(5, 32'h2, "R8");
    idle();
    rd(2, 32'h04, "R8");

    // R9 data clear collides with read load
    wr(1, 32'd5, "R9");
    wr(2, 32'h1, "R9");
    wr(5, 32'h2, "R9");
    wr(2, 32'h1, "R9");
    idle();
    rd(2, 32'h48, "R9");

    // R9 status write collides with read completion
    wr(5, 32'h2, "R9");
    wr(0, 32'h6, "R9");
    idle();
    rd(0, 32'h7, "R9");

    // R9 status write collides with program completion: byte 9 bit 1
    wr(1, (32'd1 << 10) | 32'd9, "R9");
    wr(5, 32'h1, "R9");
    wr(5, FIRE, "R9");
    wr(0, 32'h2, "R9");
    rd(0, 32'h3, "R9");
    wr(5, 32'h2, "R4");
    idle();
    rd(2, 32'h02, "R4");

    // R10 undecoded offsets
    rd(6, 32'h0, "R10");
    rd(15, 32'h0, "R10");
    wr(7, 32'hFFFF_FFFF, "R10");
    wr(6, 32'h0000_0002, "R10");
    idle();
    rd(3, 32'hA5A5_0F0F, "R10");
    rd(0, 32'h3, "R10");
    rd(2, 32'h02, "R10");

    repeat (4) idle();
    done_flag = 1'b1;
    summary();
    $finish;
  end

endmodule